// File: doc/BRIEF.md
# Register Stack with Full and Empty Flags

This block is a last-in first-out store of 64 data words held in registers and addressed by a 6-bit stack pointer. A push first advances the pointer by one and then writes the incoming word at the new pointer location. A pop first copies the word at the current pointer into an output register and then moves the pointer back by one. The pointer wraps modulo 64.

Two flags report the fill state. Both conditions are detected as "pointer is zero after the update". After a push, a zero pointer means the stack is full. After a pop, a zero pointer means it is empty. With this scheme, location 0 receives the final word of a full stack. A pop only moves the pointer and leaves the stored word in place.

Requests that would corrupt the stack are refused, and each refused request raises an error pulse. A refused request is a push into a full stack, a pop from an empty stack, or a push and pop asked for in the same cycle. A host CPU datapath uses the block as a hardware stack that feeds a data register.

Top module: `lifo_reg_stack`

## Requirements
- R1: After reset, `stackPtr` is 0, `isEmpty` is 1, `isFull` is 0, `opError` is 0 and `popData` is 0.
- R2: A legal push (`pushReq`=1, `popReq`=0, `isFull`=0) increments `stackPtr` by one at the next clock edge. It stores `pushData` at the new pointer value and clears `isEmpty`.
- R3: The push that brings `stackPtr` to 0 (the 64th push from empty) sets `isFull`, and its word lives at location 0. `isFull` and `isEmpty` are never both 1.
- R4: A legal pop (`popReq`=1, `pushReq`=0, `isEmpty`=0) places the word at the current pointer on `popData` one clock edge after the request. It decrements `stackPtr` by one and clears `isFull`.
- R5: The pop that brings `stackPtr` to 0 sets `isEmpty`.
- R6: Popped words come back in the reverse order of their pushes.
- R7: A push while `isFull`=1 is ignored. `stackPtr`, both flags and the stored words stay unchanged (the next pop still returns the word at location 0), and `opError` is 1 on the following cycle.
- R8: A pop while `isEmpty`=1 is ignored. `stackPtr`, both flags and `popData` stay unchanged, and `opError` is 1 on the following cycle.
- R9: A request with `pushReq`=1 and `popReq`=1 together is refused. Nothing changes, including `popData`, and `opError` is 1 on the following cycle.
- R10: `opError` is 1 only in the cycle after a refused request, and it is 0 after an idle cycle or a legal request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| pushReq | input | 1 | Request to push `pushData` |
| popReq | input | 1 | Request to pop the top word |
| pushData | input | 8 | Word to push |
| popData | output | 8 | Output register holding the last popped word |
| stackPtr | output | 6 | Stack pointer, which is the address of the top word |
| isFull | output | 1 | Stack holds 64 words |
| isEmpty | output | 1 | Stack holds no word |
| opError | output | 1 | Pulse: the previous cycle's request was refused |

## Verification
Every result of this block is due exactly one rising edge after the request is sampled. This covers the pointer step, the flag updates, the popped word on `popData` and the error pulse. The bench drives each request on a falling edge and holds it through a single rising edge. It withdraws the request on the next falling edge and samples all outputs at that same falling edge. The error pulse is then checked again one idle cycle later to confirm it has dropped.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic push;
    logic pop;
  } stackStrobe_t;
endpackage

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushReq,
  input  logic         popReq,
  input  logic         isFull,
  input  logic         isEmpty,
  output stackStrobe_t strobe,
  output logic         opError
);
  logic refused;

  always_comb begin
    strobe.push = pushReq & ~popReq & ~isFull;
    strobe.pop  = popReq & ~pushReq & ~isEmpty;
    refused     = (pushReq | popReq) & ~(strobe.push | strobe.pop);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opError <= 1'b0;
    else       opError <= refused;
  end
endmodule

// File: rtl/lifo_dp.sv
module lifo_dp
  import lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  stackStrobe_t      strobe,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic [PTR_W-1:0]  stackPtr,
  output logic              isFull,
  output logic              isEmpty
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] memWord [DEPTH];
  logic [PTR_W-1:0]  ptrUp;
  logic [PTR_W-1:0]  ptrDown;

  assign ptrUp   = stackPtr + PTR_W'(1);
  assign ptrDown = stackPtr - PTR_W'(1);

  // One register word per location, written at the pre-incremented pointer
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (strobe.push && (ptrUp == PTR_W'(g))) memWord[g] <= pushData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= '0;
      isFull   <= 1'b0;
      isEmpty  <= 1'b1;
      popData  <= '0;
    end else if (strobe.push) begin
      stackPtr <= ptrUp;
      isFull   <= (ptrUp == '0);
      isEmpty  <= 1'b0;
    end else if (strobe.pop) begin
      popData  <= memWord[stackPtr];
      stackPtr <= ptrDown;
      isEmpty  <= (ptrDown == '0);
      isFull   <= 1'b0;
    end
  end
endmodule

// File: rtl/lifo_reg_stack.sv
module lifo_reg_stack
  import lifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData,
  output logic [PTR_W-1:0]  stackPtr,
  output logic              isFull,
  output logic              isEmpty,
  output logic              opError
);
  stackStrobe_t strobe;

  lifo_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pushReq (pushReq),
    .popReq  (popReq),
    .isFull  (isFull),
    .isEmpty (isEmpty),
    .strobe  (strobe),
    .opError (opError)
  );

  lifo_dp #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .pushData (pushData),
    .popData  (popData),
    .stackPtr (stackPtr),
    .isFull   (isFull),
    .isEmpty  (isEmpty)
  );
endmodule

// File: rtl/lifo_reg_stack_checker.sv
module lifo_reg_stack_checker #(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushReq,
  input logic              popReq,
  input logic [DATA_W-1:0] popData,
  input logic [PTR_W-1:0]  stackPtr,
  input logic              isFull,
  input logic              isEmpty,
  input logic              opError
);
  logic legalPush, legalPop;
  assign legalPush = pushReq & ~popReq & ~isFull;
  assign legalPop  = popReq & ~pushReq & ~isEmpty;

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    legalPush |=> (stackPtr == $past(stackPtr) + PTR_W'(1)) && !isEmpty);

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(isFull && isEmpty));

  assert_full_at_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> stackPtr == '0);

  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    legalPop |=> (stackPtr == $past(stackPtr) - PTR_W'(1)) && !isFull);

  assert_empty_at_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> stackPtr == '0);

  assert_full_push_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !popReq && isFull) |=> $stable(stackPtr) && isFull && opError);

  assert_empty_pop_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && isEmpty) |=> $stable(stackPtr) && $stable(popData) && isEmpty && opError);

  assert_both_refused_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |=> $stable(stackPtr) && $stable(popData) && opError);

  assert_no_error_R10: assert property (@(posedge clk) disable iff (!rstN)
    (legalPush || legalPop || (!pushReq && !popReq)) |=> !opError);
endmodule

bind lifo_reg_stack lifo_reg_stack_checker #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .pushReq  (pushReq),
  .popReq   (popReq),
  .popData  (popData),
  .stackPtr (stackPtr),
  .isFull   (isFull),
  .isEmpty  (isEmpty),
  .opError  (opError)
);

// File: tb/test_lifo_reg_stack.sv
module test_lifo_reg_stack;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pushReq = 1'b0;
  logic       popReq = 1'b0;
  logic [7:0] pushData = '0;
  logic [7:0] popData;
  logic [5:0] stackPtr;
  logic       isFull, isEmpty, opError;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  lifo_reg_stack i_lifo_reg_stack (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq),
    .pushData(pushData), .popData(popData), .stackPtr(stackPtr),
    .isFull(isFull), .isEmpty(isEmpty), .opError(opError)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  // Drive one request for one rising edge; results sampled at the following falling edge
  task automatic step(input bit push, input bit pop, input logic [7:0] data);
    pushReq = push; popReq = pop; pushData = data;
    @(posedge clk);
    @(negedge clk);
    pushReq = 1'b0; popReq = 1'b0;
  endtask

  task automatic checkState(input string req, input int sp, input bit full, input bit empty, input bit err);
    check(req, "stackPtr", stackPtr, sp);
    check(req, "isFull", isFull, full);
    check(req, "isEmpty", isEmpty, empty);
    check(req, "opError", opError, err);
  endtask

  task automatic testReset();
    checkState("R1", 0, 0, 1, 0);
    check("R1", "popData", popData, 0);
  endtask

  task automatic testBasicPush();
    step(1, 0, 8'h11); checkState("R2", 1, 0, 0, 0);
    step(1, 0, 8'h22); checkState("R2", 2, 0, 0, 0);
    step(1, 0, 8'h33); checkState("R2", 3, 0, 0, 0);
  endtask

  task automatic testLifoPop();
    step(0, 1, 0); check("R6", "popData", popData, 8'h33); checkState("R4", 2, 0, 0, 0);
    step(0, 1, 0); check("R6", "popData", popData, 8'h22); checkState("R4", 1, 0, 0, 0);
    step(0, 1, 0); check("R4", "popData", popData, 8'h11); checkState("R5", 0, 0, 1, 0);
  endtask

  task automatic testEmptyPop();
    step(0, 1, 0);
    checkState("R8", 0, 0, 1, 1);
    check("R8", "popData", popData, 8'h11);
    step(0, 0, 0);
    check("R10", "opError after idle", opError, 0);
  endtask

  task automatic testFill();
    for (int i = 0; i < 64; i++) begin
      step(1, 0, 8'(8'h40 + i));
      if (i == 62) checkState("R3", 63, 0, 0, 0);
    end
    checkState("R3", 0, 1, 0, 0);
    step(1, 0, 8'hEE);
    checkState("R7", 0, 1, 0, 1);
    step(0, 1, 0);
    check("R7", "popData from location 0", popData, 8'h7F);
    checkState("R4", 63, 0, 0, 0);
    step(0, 1, 0);
    check("R6", "popData", popData, 8'h7E);
    check("R10", "opError after legal pop", opError, 0);
  endtask

  task automatic testBoth();
    step(1, 1, 8'h99);
    checkState("R9", 62, 0, 0, 1);
    check("R9", "popData", popData, 8'h7E);
    step(0, 0, 0);
    check("R10", "opError after idle", opError, 0);
  endtask

  task automatic testDrain();
    for (int i = 61; i >= 0; i--) begin
      step(0, 1, 0);
      check("R6", "popData drain", popData, 8'h40 + i);
    end
    checkState("R5", 0, 0, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasicPush();
    testLifoPop();
    testEmptyPop();
    testFill();
    testBoth();
    testDrain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule